// File: doc/BRIEF.md
# Tag Check Fault Mode Dispatcher

When a memory tag check fails, this block decides how the failure is reported. Each failure arrives as a one-cycle event. The event carries five things: the failing pointer, a flag that marks a store, the exception level that owns the fault status, a flag that says whether the translation regime is split into two address ranges, and the system control register value for that regime.

A two-bit reporting mode is taken from the control register. The field position depends on whether the regime runs at user level. The mode selects one of four behaviours:
- do nothing;
- raise a synchronous fault request;
- set a sticky asynchronous status bit;
- report by access direction, where loads trap synchronously and stores only set the status bit.

Each exception level has its own two-bit sticky status register. Software clears it with an explicit write-one-to-clear request.

The synchronous request is a registered single-cycle pulse. It carries the failing address and the store flag to the exception logic, which builds the full syndrome and does the vectoring.

Top module: `tag_fault_dispatch`

## Requirements
- R1: After reset, `sync_fault` is 0 and every bit of `async_status` is 0.
- R2: The mode field is `evt_ctrl[39:38]` when `evt_user` is 1 and `evt_ctrl[41:40]` when `evt_user` is 0. The other field is ignored.
- R3: Mode 0 has no effect: no synchronous pulse and no status change.
- R4: In mode 1, `sync_fault` is 1 in the cycle after the event. In that cycle `sync_addr` equals the event address and `sync_write` equals the event store flag. The status registers do not change.
- R5: In mode 2, the event sets one status bit and raises no synchronous pulse.
- R6: In mode 3, a load (`evt_write`=0) behaves as in mode 1 and a store (`evt_write`=1) behaves as in mode 2.
- R7: The bit that gets set is `evt_addr[55]` when `evt_two_ranges` is 1 and bit 0 otherwise. It is bit `2*evt_el + index` of `async_status`.
- R8: Status bits are ORed in and stay set through any number of later events.
- R9: A clear request resets the bits of `sw_clr_mask` in the status register of level `sw_clr_el` only. The registers of other levels are not changed.
- R10: If an event sets a bit and a clear request targets the same bit in the same cycle, the bit ends up set.
- R11: `sync_fault` is high for exactly one cycle per synchronous event. With no synchronous event in the previous cycle it is 0.
- R12: An event changes only the status register of its own level `evt_el`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | A tag check failure this cycle |
| evt_addr | input | 64 | Failing pointer |
| evt_write | input | 1 | 1 for a store, 0 for a load |
| evt_el | input | 2 | Exception level whose status register records the fault |
| evt_user | input | 1 | Regime is user level (selects the low mode field) |
| evt_two_ranges | input | 1 | Regime has two address ranges |
| evt_ctrl | input | 64 | System control register of the regime |
| sw_clr_en | input | 1 | Software clear request |
| sw_clr_el | input | 2 | Level whose status register is cleared |
| sw_clr_mask | input | 2 | Write-one-to-clear mask |
| sync_fault | output | 1 | Synchronous fault request pulse |
| sync_addr | output | 64 | Address of the synchronous fault |
| sync_write | output | 1 | Store flag of the synchronous fault |
| async_status | output | 8 | Sticky status, two bits per level, level 0 in the low bits |

## Verification
A fault event that sets a sticky bit and a software clear of the same register can land in the same cycle. The bench provokes this directly: it clears the exact bit that an asynchronous or asymmetric-store event sets, and it also issues clears that overlap only part of the mask. A reference model applies the clear first and the set after. The register is then compared one cycle later, so the set must win while the other masked bit is still cleared.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

   typedef enum logic [1:0] {
      FM_SILENT = 2'd0,
      FM_SYNC   = 2'd1,
      FM_ASYNC  = 2'd2,
      FM_ASYM   = 2'd3
   } fault_mode_e;

   typedef struct packed {
      logic raise_sync;
      logic set_async;
   } fault_action_t;

   function automatic fault_action_t mode_action(fault_mode_e m, logic is_store);
      fault_action_t a;
      a = '0;
      case (m)
         FM_SYNC:  a.raise_sync = 1'b1;
         FM_ASYNC: a.set_async  = 1'b1;
         FM_ASYM: begin
            a.raise_sync = ~is_store;
            a.set_async  = is_store;
         end
         default: a = '0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/tfd_mode_decode.sv
module tfd_mode_decode
   import tfd_pkg::*;
#(
   parameter int CTRL_W   = 64,
   parameter int USER_LSB = 38,
   parameter int PRIV_LSB = 40
) (
   input  logic              valid,
   input  logic              is_store,
   input  logic              user_regime,
   input  logic [CTRL_W-1:0] ctrl,
   output fault_action_t     action
);

   localparam int FIELD_W = 2;

   generate
      if (USER_LSB + FIELD_W > CTRL_W) begin : g_bad_user
         $error("user mode field lies outside the control word");
      end
      if (PRIV_LSB + FIELD_W > CTRL_W) begin : g_bad_priv
         $error("privileged mode field lies outside the control word");
      end
   endgenerate

   logic [FIELD_W-1:0] user_field;
   logic [FIELD_W-1:0] priv_field;
   fault_mode_e        mode;

   assign user_field = ctrl[USER_LSB +: FIELD_W];
   assign priv_field = ctrl[PRIV_LSB +: FIELD_W];

   always_comb begin
      mode   = fault_mode_e'(user_regime ? user_field : priv_field);
      action = valid ? mode_action(mode, is_store) : '0;
   end

endmodule

// File: rtl/tfd_status_bank.sv
module tfd_status_bank #(
   parameter int NUM_EL = 4,
   parameter int EL_W   = 2,
   parameter int STAT_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     set_en,
   input  logic [EL_W-1:0]          set_el,
   input  logic [$clog2(STAT_W)-1:0] set_idx,
   input  logic                     clr_en,
   input  logic [EL_W-1:0]          clr_el,
   input  logic [STAT_W-1:0]        clr_mask,
   output logic [NUM_EL*STAT_W-1:0] status
);

   genvar e;
   generate
      for (e = 0; e < NUM_EL; e++) begin : g_el
         logic [STAT_W-1:0] reg_q;
         logic [STAT_W-1:0] set_vec;
         logic [STAT_W-1:0] clr_vec;

         always_comb begin
            set_vec = '0;
            if (set_en && (set_el == EL_W'(e))) set_vec[set_idx] = 1'b1;
            clr_vec = (clr_en && (clr_el == EL_W'(e))) ? clr_mask : '0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_q <= '0;
            else        reg_q <= (reg_q & ~clr_vec) | set_vec;
         end

         assign status[e*STAT_W +: STAT_W] = reg_q;
      end
   endgenerate

endmodule

// File: rtl/tfd_sync_capture.sv
module tfd_sync_capture #(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_store,
   output logic              pulse,
   output logic [ADDR_W-1:0] addr_q,
   output logic              store_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse   <= 1'b0;
         addr_q  <= '0;
         store_q <= 1'b0;
      end else begin
         pulse <= fire;
         if (fire) begin
            addr_q  <= addr;
            store_q <= is_store;
         end
      end
   end

endmodule

// File: rtl/tag_fault_dispatch.sv
module tag_fault_dispatch
   import tfd_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int CTRL_W    = 64,
   parameter int NUM_EL    = 4,
   parameter int USER_LSB  = 38,
   parameter int PRIV_LSB  = 40,
   parameter int RANGE_BIT = 55,
   localparam int EL_W     = $clog2(NUM_EL),
   localparam int STAT_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     evt_valid,
   input  logic [ADDR_W-1:0]        evt_addr,
   input  logic                     evt_write,
   input  logic [EL_W-1:0]          evt_el,
   input  logic                     evt_user,
   input  logic                     evt_two_ranges,
   input  logic [CTRL_W-1:0]        evt_ctrl,
   input  logic                     sw_clr_en,
   input  logic [EL_W-1:0]          sw_clr_el,
   input  logic [STAT_W-1:0]        sw_clr_mask,
   output logic                     sync_fault,
   output logic [ADDR_W-1:0]        sync_addr,
   output logic                     sync_write,
   output logic [NUM_EL*STAT_W-1:0] async_status
);

   generate
      if (NUM_EL < 2) begin : g_bad_el
         $error("NUM_EL must be at least 2");
      end
      if (RANGE_BIT >= ADDR_W) begin : g_bad_range
         $error("RANGE_BIT must index into the address");
      end
   endgenerate

   fault_action_t act;
   logic          stat_idx;

   tfd_mode_decode #(
      .CTRL_W  (CTRL_W),
      .USER_LSB(USER_LSB),
      .PRIV_LSB(PRIV_LSB)
   ) u_decode (
      .valid      (evt_valid),
      .is_store   (evt_write),
      .user_regime(evt_user),
      .ctrl       (evt_ctrl),
      .action     (act)
   );

   assign stat_idx = evt_two_ranges & evt_addr[RANGE_BIT];

   tfd_status_bank #(
      .NUM_EL(NUM_EL),
      .EL_W  (EL_W),
      .STAT_W(STAT_W)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (act.set_async),
      .set_el  (evt_el),
      .set_idx (stat_idx),
      .clr_en  (sw_clr_en),
      .clr_el  (sw_clr_el),
      .clr_mask(sw_clr_mask),
      .status  (async_status)
   );

   tfd_sync_capture #(
      .ADDR_W(ADDR_W)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (act.raise_sync),
      .addr    (evt_addr),
      .is_store(evt_write),
      .pulse   (sync_fault),
      .addr_q  (sync_addr),
      .store_q (sync_write)
   );

endmodule

// File: rtl/tfd_checker.sv
module tfd_checker #(
   parameter int ADDR_W = 64,
   parameter int NUM_EL = 4,
   parameter int EL_W   = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 evt_valid,
   input logic [ADDR_W-1:0]    evt_addr,
   input logic                 evt_write,
   input logic                 sw_clr_en,
   input logic                 sync_fault,
   input logic [ADDR_W-1:0]    sync_addr,
   input logic                 sync_write,
   input logic [NUM_EL*2-1:0]  async_status
);

   // R11
   pulse_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> !sync_fault);

   // R4
   sync_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |=> (!sync_fault || (sync_addr == $past(evt_addr) && sync_write == $past(evt_write))));

   // R8
   sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_clr_en |=> ((async_status & $past(async_status)) == $past(async_status)));

   // R3
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_valid && !sw_clr_en) |=> $stable(async_status));

   // R12
   single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |=> ($countones(async_status & ~$past(async_status)) <= 1));

endmodule

bind tag_fault_dispatch tfd_checker #(
   .ADDR_W(ADDR_W),
   .NUM_EL(NUM_EL),
   .EL_W  (EL_W)
) u_tfd_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_valid   (evt_valid),
   .evt_addr    (evt_addr),
   .evt_write   (evt_write),
   .sw_clr_en   (sw_clr_en),
   .sync_fault  (sync_fault),
   .sync_addr   (sync_addr),
   .sync_write  (sync_write),
   .async_status(async_status)
);

// File: tb/tb_tag_fault_dispatch.sv
module tb_tag_fault_dispatch;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_EL     = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [63:0] evt_addr = '0;
   logic        evt_write = 1'b0;
   logic [1:0]  evt_el = '0;
   logic        evt_user = 1'b0;
   logic        evt_two_ranges = 1'b0;
   logic [63:0] evt_ctrl = '0;
   logic        sw_clr_en = 1'b0;
   logic [1:0]  sw_clr_el = '0;
   logic [1:0]  sw_clr_mask = '0;
   logic        sync_fault;
   logic [63:0] sync_addr;
   logic        sync_write;
   logic [7:0]  async_status;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [7:0]  m_status = '0;
   logic [63:0] m_addr   = '0;
   logic        m_write  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tag_fault_dispatch dut (
      .clk(clk), .rst_n(rst_n),
      .evt_valid(evt_valid), .evt_addr(evt_addr), .evt_write(evt_write),
      .evt_el(evt_el), .evt_user(evt_user), .evt_two_ranges(evt_two_ranges),
      .evt_ctrl(evt_ctrl), .sw_clr_en(sw_clr_en), .sw_clr_el(sw_clr_el),
      .sw_clr_mask(sw_clr_mask), .sync_fault(sync_fault), .sync_addr(sync_addr),
      .sync_write(sync_write), .async_status(async_status)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] sel_mode(logic user, logic [63:0] c);
      return user ? c[39:38] : c[41:40];
   endfunction

   function automatic logic [63:0] mkctrl(logic [1:0] um, logic [1:0] pm);
      logic [63:0] c;
      c = {$urandom, $urandom};
      c[39:38] = um;
      c[41:40] = pm;
      return c;
   endfunction

   task automatic step(input logic v, input logic [63:0] a, input logic w,
                       input logic [1:0] el, input logic u, input logic two,
                       input logic [63:0] c, input logic ce, input logic [1:0] cel,
                       input logic [1:0] cm, input string tag);
      logic [1:0] md;
      logic       e_sync, e_set, idx;
      logic [1:0] r;
      evt_valid = v; evt_addr = a; evt_write = w; evt_el = el; evt_user = u;
      evt_two_ranges = two; evt_ctrl = c; sw_clr_en = ce; sw_clr_el = cel;
      sw_clr_mask = cm;
      @(posedge clk);
      @(negedge clk);
      md     = sel_mode(u, c);
      e_sync = v && (md == 2'd1 || (md == 2'd3 && !w));
      e_set  = v && (md == 2'd2 || (md == 2'd3 && w));
      idx    = two ? a[55] : 1'b0;
      for (int e = 0; e < NUM_EL; e++) begin
         r = m_status[e*2 +: 2];
         if (ce && cel == 2'(e)) r = r & ~cm;
         if (e_set && el == 2'(e)) r[idx] = 1'b1;
         m_status[e*2 +: 2] = r;
      end
      if (e_sync) begin
         m_addr  = a;
         m_write = w;
      end
      check(sync_fault === e_sync, {tag, " sync_fault"}, 64'(sync_fault), 64'(e_sync));
      if (e_sync) begin
         check(sync_addr === m_addr, {tag, " sync_addr"}, sync_addr, m_addr);
         check(sync_write === m_write, {tag, " sync_write"}, 64'(sync_write), 64'(m_write));
      end
      check(async_status === m_status, {tag, " status"}, 64'(async_status), 64'(m_status));
   endtask

   task automatic idle(input string tag);
      step(0, '0, 0, 0, 0, 0, '0, 0, 0, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'h7a61);
      repeat (3) @(negedge clk);
      // R1 reset state
      check(sync_fault === 1'b0, "R1 sync_fault", 64'(sync_fault), 0);
      check(async_status === 8'h00, "R1 status", 64'(async_status), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R3: user field 0, privileged field 1 -> nothing
      step(1, 64'h1234, 0, 1, 1, 0, mkctrl(2'd0, 2'd1), 0, 0, 0, "R2 R3 user silent");
      // R2 / R4: privileged field 1 used, user field 0 ignored
      step(1, 64'hABCD_0000_1111, 1, 1, 0, 0, mkctrl(2'd0, 2'd1), 0, 0, 0, "R2 R4 priv sync");
      // R11 pulse drops
      idle("R11 pulse drop");
      // R5 / R7 two ranges with bit 55 set -> index 1 at level 2
      step(1, 64'h0080_0000_0000_0000, 0, 2, 1, 1, mkctrl(2'd2, 2'd0), 0, 0, 0, "R5 R7 two ranges");
      // R7 single range ignores bit 55 -> index 0 at level 3
      step(1, 64'h0080_0000_0000_0000, 0, 3, 0, 0, mkctrl(2'd0, 2'd2), 0, 0, 0, "R7 single range");
      // R6 asymmetric load -> sync, store -> async
      step(1, 64'h5555, 0, 0, 1, 0, mkctrl(2'd3, 2'd0), 0, 0, 0, "R6 asym load");
      step(1, 64'h0080_0000_0000_7777, 1, 1, 1, 1, mkctrl(2'd3, 2'd0), 0, 0, 0, "R6 asym store");
      // R8 repeated set keeps bits
      step(1, 64'h0, 1, 1, 1, 1, mkctrl(2'd2, 2'd0), 0, 0, 0, "R8 sticky");
      // R9 clear other level leaves level 1, clears level 3
      step(0, '0, 0, 0, 0, 0, '0, 1, 3, 2'b11, "R9 clear level3");
      // R10 set and clear the same bit of level 2 (bit1) with mask 11
      step(1, 64'h0080_0000_0000_0000, 1, 2, 1, 1, mkctrl(2'd3, 2'd0), 1, 2, 2'b11, "R10 set wins");
      // R12 event at level 0 leaves others
      step(1, 64'h0, 1, 0, 0, 0, mkctrl(2'd1, 2'd2), 0, 0, 0, "R12 own level");
      // R11 back-to-back sync events
      step(1, 64'h11, 0, 0, 0, 0, mkctrl(2'd0, 2'd1), 0, 0, 0, "R11 back1");
      step(1, 64'h22, 1, 0, 0, 0, mkctrl(2'd0, 2'd1), 0, 0, 0, "R11 back2");
      idle("R11 idle");
      // R9 clear everything
      for (int e = 0; e < NUM_EL; e++)
         step(0, '0, 0, 0, 0, 0, '0, 1, 2'(e), 2'b11, "R9 clear all");

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [1:0] um, pm;
         um = 2'($urandom_range(0, 3));
         pm = 2'($urandom_range(0, 3));
         step(($urandom_range(0, 3) != 0), {$urandom, $urandom}, 1'($urandom),
              2'($urandom), 1'($urandom), 1'($urandom), mkctrl(um, pm),
              ($urandom_range(0, 3) == 0), 2'($urandom), 2'($urandom),
              "R3 R4 R5 R6 R8 R10 random");
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule